// File: doc/BRIEF.md
# SRAM Power-Cycle Sequencer

This block drives the power and initialisation control levels of a small SRAM array whose start-up contents act as a physical fingerprint. Before the array is brought up again it must be fully discharged. A single request therefore has to walk the array down into sleep, hold every power switch on for a programmable number of milliseconds, release the switches in two timed stages, bring the array back up and end with a low pulse on the init line. A second request powers the array down and leaves it parked with the switches held on.

The control outputs are decoded from one registered phase, so each output change happens on the clock edge that changes the phase. All hold times come from one shared down-counter. The millisecond discharge length is scaled by the clock rate in MHz and by the number of microseconds per millisecond. The two microsecond holds each last one cycle longer than a microsecond. A one-cycle done pulse marks arrival in a resting phase. A request that arrives while a sequence is running is ignored.

Top module: `pwrcyc_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, every control output and `done` are 0.
- R2: A power-cycle request drives the output word {ram_on, clk_dis, ram_init, lg_a, lg_p, sm_a, sm_p} (bit 6 down to bit 0) through 0x70, 0x30, 0x10, 0x1F, 0x1C, 0x10, 0x30, 0x70, 0x50, 0x70, 0x60 and then rests at 0x40. The first word appears on the clock edge that accepts the request. Every word except 0x1F and 0x1C and the 0x10 that follows 0x1C lasts exactly one cycle.
- R3: The all-switches word 0x1F lasts `discharge_ms` × US_PER_MS × CLK_MHZ cycles, or one cycle when `discharge_ms` is 0.
- R4: The small-switches-released word 0x1C and the following all-released word 0x10 each last CLK_MHZ + 1 cycles. The large switches never drop while a small switch is still on.
- R5: `done` is high for exactly one cycle: the first cycle of the resting phase (0x40 after a power cycle, 0x1F after a power-off). It is low at all other times.
- R6: A power-off request drives 0x70, 0x30, 0x10 (one cycle each) and then 0x1F for the discharge time of R3. The word then stays at 0x1F until the next request.
- R7: Either request strobe that arrives while a sequence is running has no effect on the output words or their durations.
- R8: `discharge_ms` is captured when a request is accepted. Later changes do not alter the running discharge hold.
- R9: When both strobes are high in the same cycle while resting, the power-cycle sequence runs.
- R10: A new request is accepted from any resting state: off after reset, powered after a cycle, or parked after a power-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_req | input | 1 | Strobe: start a full power cycle |
| off_req | input | 1 | Strobe: power down and park |
| discharge_ms | input | MS_W | Discharge hold length in milliseconds |
| ram_on | output | 1 | Array supply enable |
| clk_dis | output | 1 | Array clock disable |
| ram_init | output | 1 | Array init level (low pulse resets it) |
| lg_a | output | 1 | Large power switch, array side |
| lg_p | output | 1 | Large power switch, periphery side |
| sm_a | output | 1 | Small power switch, array side |
| sm_p | output | 1 | Small power switch, periphery side |
| done | output | 1 | One-cycle pulse on reaching a resting phase |

## Verification
A wrong phase register shows up at once, because the output word is a direct decode of the phase. A skipped or repeated step changes the run-length trace of the word in the very cycle it happens. A timer that loads the wrong length does not change the words, but it stretches or shortens a hold. This is only visible as a run length that differs from the arithmetic value for the programmed milliseconds, so the bench sweeps every `discharge_ms` value and compares every run length. A misplaced done flag or a request accepted while busy appears within one cycle as an extra pulse or as a restart to 0x70.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [3:0] {
      PH_OFF     = 4'd0,
      PH_CKOFF   = 4'd1,
      PH_SLEEP   = 4'd2,
      PH_CKON    = 4'd3,
      PH_DRAIN   = 4'd4,
      PH_REL_SM  = 4'd5,
      PH_REL_LG  = 4'd6,
      PH_UP_A    = 4'd7,
      PH_UP_B    = 4'd8,
      PH_UP_C    = 4'd9,
      PH_PULSE_A = 4'd10,
      PH_PULSE_B = 4'd11,
      PH_RUN     = 4'd12,
      PH_PARK    = 4'd13
   } phase_t;

   typedef struct packed {
      logic ram_on;
      logic clk_dis;
      logic ram_init;
      logic lg_a;
      logic lg_p;
      logic sm_a;
      logic sm_p;
   } ctrl_t;

   function automatic ctrl_t word_of(input phase_t ph);
      ctrl_t w;
      w = '0;
      case (ph)
         PH_CKOFF, PH_UP_B, PH_PULSE_A: begin
            w.ram_on = 1'b1; w.clk_dis = 1'b1; w.ram_init = 1'b1;
         end
         PH_SLEEP, PH_UP_A: begin
            w.clk_dis = 1'b1; w.ram_init = 1'b1;
         end
         PH_CKON, PH_REL_LG: w.ram_init = 1'b1;
         PH_DRAIN, PH_PARK: begin
            w.ram_init = 1'b1;
            w.lg_a = 1'b1; w.lg_p = 1'b1; w.sm_a = 1'b1; w.sm_p = 1'b1;
         end
         PH_REL_SM: begin
            w.ram_init = 1'b1; w.lg_a = 1'b1; w.lg_p = 1'b1;
         end
         PH_UP_C: begin
            w.ram_on = 1'b1; w.ram_init = 1'b1;
         end
         PH_PULSE_B: begin
            w.ram_on = 1'b1; w.clk_dis = 1'b1;
         end
         PH_RUN: w.ram_on = 1'b1;
         default: w = '0;
      endcase
      return w;
   endfunction

   function automatic logic is_rest(input phase_t ph);
      return (ph == PH_OFF) || (ph == PH_RUN) || (ph == PH_PARK);
   endfunction

endpackage

// File: rtl/pcs_hold_timer.sv
module pcs_hold_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/pcs_dur_calc.sv
module pcs_dur_calc
   import pcs_pkg::*;
#(
   parameter int MS_W      = 8,
   parameter int CLK_MHZ   = 100,
   parameter int US_PER_MS = 1000,
   parameter int CNT_W     = 25
) (
   input  phase_t           phase_i,
   input  logic [MS_W-1:0]  ms_i,
   output logic [CNT_W-1:0] dur_m1_o
);

   localparam int CYC_PER_MS = US_PER_MS * CLK_MHZ;
   localparam logic [CNT_W-1:0] CPM_V    = CNT_W'(CYC_PER_MS);
   localparam logic [CNT_W-1:0] US_M1_V  = CNT_W'(CLK_MHZ);

   logic [CNT_W-1:0] prod;

   assign prod = CNT_W'(ms_i) * CPM_V;

   always_comb begin
      case (phase_i)
         PH_DRAIN:             dur_m1_o = (prod == '0) ? '0 : prod - 1'b1;
         PH_REL_SM, PH_REL_LG: dur_m1_o = US_M1_V;
         default:              dur_m1_o = '0;
      endcase
   end

endmodule

// File: rtl/pcs_phase_fsm.sv
module pcs_phase_fsm
   import pcs_pkg::*;
#(
   parameter int MS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cycle_req,
   input  logic            off_req,
   input  logic [MS_W-1:0] discharge_ms,
   input  logic            expired,
   output phase_t          phase_o,
   output phase_t          ld_phase_o,
   output logic            load_o,
   output logic [MS_W-1:0] ms_o,
   output logic            done_o
);

   phase_t          phase_q, nxt;
   logic            off_mode_q;
   logic [MS_W-1:0] ms_q;
   logic            done_q;
   logic            busy, accept, advance;

   assign busy    = !is_rest(phase_q);
   assign accept  = !busy && (cycle_req || off_req);
   assign advance = busy && expired;

   always_comb begin
      case (phase_q)
         PH_CKOFF:   nxt = PH_SLEEP;
         PH_SLEEP:   nxt = PH_CKON;
         PH_CKON:    nxt = PH_DRAIN;
         PH_DRAIN:   nxt = off_mode_q ? PH_PARK : PH_REL_SM;
         PH_REL_SM:  nxt = PH_REL_LG;
         PH_REL_LG:  nxt = PH_UP_A;
         PH_UP_A:    nxt = PH_UP_B;
         PH_UP_B:    nxt = PH_UP_C;
         PH_UP_C:    nxt = PH_PULSE_A;
         PH_PULSE_A: nxt = PH_PULSE_B;
         PH_PULSE_B: nxt = PH_RUN;
         default:    nxt = phase_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_OFF;
         off_mode_q <= 1'b0;
         ms_q       <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= advance && is_rest(nxt);
         if (accept) begin
            phase_q    <= PH_CKOFF;
            off_mode_q <= !cycle_req;
            ms_q       <= discharge_ms;
         end else if (advance) begin
            phase_q <= nxt;
         end
      end
   end

   assign phase_o    = phase_q;
   assign ld_phase_o = accept ? PH_CKOFF : nxt;
   assign load_o     = accept || advance;
   assign ms_o       = ms_q;
   assign done_o     = done_q;

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !expired) |=> (phase_q == $past(phase_q))); // R3

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (cycle_req || off_req) && phase_q != PH_PULSE_B) |=> (phase_q != PH_CKOFF)); // R7

   AST_REST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (phase_q == PH_CKOFF)); // R10

   AST_BOTH_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cycle_req && off_req) |=> !off_mode_q); // R9

   AST_MS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ms_q) || (phase_q == PH_CKOFF)); // R8

endmodule

// File: rtl/pwrcyc_seq.sv
module pwrcyc_seq
   import pcs_pkg::*;
#(
   parameter int MS_W      = 8,
   parameter int CLK_MHZ   = 100,
   parameter int US_PER_MS = 1000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cycle_req,
   input  logic            off_req,
   input  logic [MS_W-1:0] discharge_ms,
   output logic            ram_on,
   output logic            clk_dis,
   output logic            ram_init,
   output logic            lg_a,
   output logic            lg_p,
   output logic            sm_a,
   output logic            sm_p,
   output logic            done
);

   localparam int CYC_PER_MS = US_PER_MS * CLK_MHZ;
   localparam int MAX_DRAIN  = ((1 << MS_W) - 1) * CYC_PER_MS;
   localparam int MAX_HOLD   = (MAX_DRAIN > CLK_MHZ) ? MAX_DRAIN : CLK_MHZ;
   localparam int CNT_W      = (MAX_HOLD < 2) ? 1 : $clog2(MAX_HOLD + 1);

   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("pwrcyc_seq: CLK_MHZ must be at least 1");
   end
   if (US_PER_MS < 1) begin : g_bad_scale
      $error("pwrcyc_seq: US_PER_MS must be at least 1");
   end
   if (MS_W < 1 || MS_W > 16) begin : g_bad_msw
      $error("pwrcyc_seq: MS_W out of range 1..16");
   end

   phase_t           phase, ld_phase;
   logic             load, expired;
   logic [MS_W-1:0]  ms_q;
   logic [CNT_W-1:0] dur_m1;
   ctrl_t            word;

   pcs_phase_fsm #(.MS_W(MS_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cycle_req    (cycle_req),
      .off_req      (off_req),
      .discharge_ms (discharge_ms),
      .expired      (expired),
      .phase_o      (phase),
      .ld_phase_o   (ld_phase),
      .load_o       (load),
      .ms_o         (ms_q),
      .done_o       (done)
   );

   pcs_dur_calc #(
      .MS_W      (MS_W),
      .CLK_MHZ   (CLK_MHZ),
      .US_PER_MS (US_PER_MS),
      .CNT_W     (CNT_W)
   ) u_dur (
      .phase_i  (ld_phase),
      .ms_i     (ms_q),
      .dur_m1_o (dur_m1)
   );

   pcs_hold_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (dur_m1),
      .expired  (expired)
   );

   assign word     = word_of(phase);
   assign ram_on   = word.ram_on;
   assign clk_dis  = word.clk_dis;
   assign ram_init = word.ram_init;
   assign lg_a     = word.lg_a;
   assign lg_p     = word.lg_p;
   assign sm_a     = word.sm_a;
   assign sm_p     = word.sm_p;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5

   AST_DONE_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> is_rest(phase)); // R5

   AST_LARGE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lg_a) |-> (!sm_a && !sm_p)); // R4

   AST_SWITCH_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sm_a || lg_a) |-> (!ram_on && ram_init)); // R2

endmodule

// File: tb/pwrcyc_seq_test.sv
module pwrcyc_seq_test;

   localparam int MS_W      = 4;
   localparam int CLK_MHZ   = 2;
   localparam int US_PER_MS = 10;
   localparam int CPM       = CLK_MHZ * US_PER_MS;
   localparam int UHOLD     = CLK_MHZ + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cycle_req = 1'b0;
   logic            off_req = 1'b0;
   logic [MS_W-1:0] discharge_ms = '0;
   logic ram_on, clk_dis, ram_init, lg_a, lg_p, sm_a, sm_p, done;
   logic [6:0] w;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pwrcyc_seq #(.MS_W(MS_W), .CLK_MHZ(CLK_MHZ), .US_PER_MS(US_PER_MS)) uut (
      .clk(clk), .rst_n(rst_n), .cycle_req(cycle_req), .off_req(off_req),
      .discharge_ms(discharge_ms), .ram_on(ram_on), .clk_dis(clk_dis),
      .ram_init(ram_init), .lg_a(lg_a), .lg_p(lg_p), .sm_a(sm_a), .sm_p(sm_p),
      .done(done)
   );

   assign w = {ram_on, clk_dis, ram_init, lg_a, lg_p, sm_a, sm_p};

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic int drain_len(input int ms);
      return (ms == 0) ? 1 : ms * CPM;
   endfunction

   // Sample len cycles of one word with done low; optionally poke busy-time inputs.
   task automatic seg(input string tag, input logic [6:0] exp, input int len, input bit poke);
      for (int i = 0; i < len; i++) begin
         chk(tag, {1'b0, w}, {1'b0, exp});
         chk({tag, " done low R5"}, {7'b0, done}, 8'h00);
         if (poke && i == 1) begin
            cycle_req = 1'b1; off_req = 1'b1; discharge_ms = ~discharge_ms;
         end
         if (poke && i == 2) begin
            cycle_req = 1'b0; off_req = 1'b0;
         end
         @(negedge clk);
      end
   endtask

   task automatic launch(input bit cyc, input bit off, input int ms);
      @(negedge clk);
      discharge_ms = MS_W'(ms);
      cycle_req = cyc; off_req = off;
      @(negedge clk);
      cycle_req = 1'b0; off_req = 1'b0;
   endtask

   task automatic do_cycle(input int ms, input bit both, input bit poke);
      int d;
      d = drain_len(ms);
      launch(1'b1, both, ms);
      seg("R2 ckoff", 7'h70, 1, 1'b0);
      seg("R2 sleep", 7'h30, 1, 1'b0);
      seg("R2 ckon", 7'h10, 1, 1'b0);
      seg(both ? "R9 drain" : (poke ? "R8 R7 drain" : "R3 drain"), 7'h1F, d, poke);
      seg("R4 rel_small", 7'h1C, UHOLD, 1'b0);
      seg("R4 rel_large", 7'h10, UHOLD, 1'b0);
      seg("R2 up_a", 7'h30, 1, 1'b0);
      seg("R2 up_b", 7'h70, 1, 1'b0);
      seg("R2 up_c", 7'h50, 1, 1'b0);
      seg("R2 pulse_a", 7'h70, 1, 1'b0);
      seg("R2 pulse_b", 7'h60, 1, 1'b0);
      chk("R2 run word", {1'b0, w}, 8'h40);
      chk("R5 done at run", {7'b0, done}, 8'h01);
      @(negedge clk);
      chk("R5 done single", {7'b0, done}, 8'h00);
      chk("R2 run held", {1'b0, w}, 8'h40);
   endtask

   task automatic do_off(input int ms);
      launch(1'b0, 1'b1, ms);
      seg("R6 ckoff", 7'h70, 1, 1'b0);
      seg("R6 sleep", 7'h30, 1, 1'b0);
      seg("R6 ckon", 7'h10, 1, 1'b0);
      seg("R6 R3 drain", 7'h1F, drain_len(ms), 1'b0);
      chk("R6 park word", {1'b0, w}, 8'h1F);
      chk("R5 done at park", {7'b0, done}, 8'h01);
      @(negedge clk);
      seg("R6 parked", 7'h1F, 5, 1'b0);
   endtask

   initial begin
      @(negedge clk);
      chk("R1 reset word", {1'b0, w}, 8'h00);
      chk("R1 reset done", {7'b0, done}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      seg("R1 idle after reset", 7'h00, 6, 1'b0);

      // R10: first from off, then every later one from run.
      for (int ms = 0; ms < (1 << MS_W); ms++) do_cycle(ms, 1'b0, 1'b0);
      // R10: off from run, then off from park, and back through a cycle.
      for (int ms = 0; ms < (1 << MS_W); ms++) do_off(ms);
      do_cycle(3, 1'b0, 1'b0);
      // R7 R8: busy-time requests and a changed millisecond value.
      do_cycle(5, 1'b0, 1'b1);
      do_cycle(2, 1'b0, 1'b1);
      // R9: simultaneous strobes.
      do_cycle(1, 1'b1, 1'b0);
      do_off(4);
      do_cycle(0, 1'b1, 1'b0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule